// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a system watchdog that pulls a reset line unless software keeps it alive with a two-step key written over a simple register write port. The first key byte goes to one address and the second key byte to another, in consecutive bus writes. Any departure from that sequence counts as a fault and fires the reset at once. Writes to the configuration registers are only staged. They must be followed by a correct key sequence, which both commits them and refreshes the timer. If any other write comes first, the block fires the reset and throws the staged values away.

The timer counts on a clock-enable strobe taken from a separate slow oscillator, not on every system clock. A power-of-two prescaler with eight settings sits in front of a down-counter, and a valid feed reloads that counter from the committed timeout value. When the count runs out, the block drives a fixed-length reset pulse and sets a sticky status flag. The flag outlives the pulse, so code running after the reset can tell why it happened. The block's own state is cleared only by the power-on reset input.

Register map, by the 2-bit write address: 0 is the control register, with bits [2:0] selecting the prescaler and bit 7 a write-one-to-clear for the status flag. Address 1 is the timeout reload value. Address 2 takes the first key, 0xA5. Address 3 takes the second key, 0x5A.

Top module: `wdog_keyed`

## Requirements
- R1: After the power-on reset (rstN low), wdReset and tripFlag are both 0.
- R2: A valid feed is 0xA5 written to address 2 and then 0x5A written to address 3 as the next bus write, with idle cycles between them allowed. It restarts the timeout, so feeding more often than the timeout keeps wdReset low.
- R3: With wdTick high every cycle, wdReset rises exactly max(R,1) × 2^(5+n) clock cycles after the clock edge that takes the second key. R is the committed reload value and n is the committed prescaler select. A reload value of 0 behaves as 1.
- R4: Control bits [2:0] hold n, which sets a division of 2^(5+n) enabled ticks for each count of the down-counter.
- R5: A write to address 2 of any value other than 0xA5, or a write to address 3 that does not follow a first key, fires wdReset on the edge that takes that write.
- R6: After a first key, any bus write other than 0x5A to address 3 fires wdReset on the edge that takes that write.
- R7: A write to address 0 or 1 may be followed by further writes to addresses 0 and 1. The first write to any other address must be the first key, or wdReset fires on that edge.
- R8: Staged control and reload values take effect only when the next valid feed completes. A reset fired before that discards them, and the previously committed values stay in force.
- R9: Every wdReset pulse lasts exactly 32 clock cycles.
- R10: tripFlag sets whenever wdReset fires and stays set after the pulse ends. It clears when address 0 is written with bit 7 set, and the clear takes effect on that write, not at the later feed.
- R11: Bus writes made while wdReset is high are ignored. They neither lengthen the pulse nor fire a new reset afterwards.
- R12: While wdTick is low, the prescaler and the down-counter hold their values, and no timeout can occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| wdTick | input | 1 | One-cycle enable pulse from the slow watchdog oscillator |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Register write address |
| busData | input | 8 | Register write data |
| wdReset | output | 1 | Reset request pulse, active high |
| tripFlag | output | 1 | Sticky status flag: a watchdog reset has happened |

## Verification
The bench measures the timeout to the exact cycle over several prescaler and reload pairs, including a reload of zero. An off-by-one in the prescaler mask or in the counter's end condition would move the rising edge of wdReset by one step and be caught. It drives the sequence faults that are easy to miss: a repeated first key, a control write between the keys, a second key with no first key, and a second key right after a configuration write. A decoder that only compares data values, or that forgets the pending-configuration state, would let these through without a reset. It also checks that a reset fired by a fault discards staged settings, so a design that committed them early would show the new timeout. Writes made during the pulse must not stretch it, and a stalled wdTick must freeze the count, so a counter running on the raw clock would fire too early.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_KEY1   = 2'd2;
  localparam logic [1:0] ADDR_KEY2   = 2'd3;

  // Strobes from the sequence checker to the timer datapath
  typedef struct packed {
    logic feedOk;    // valid key pair completed
    logic badSeq;    // sequence fault, fire reset now
    logic ctrlWr;    // stage control register
    logic reloadWr;  // stage reload value
  } wdStrobe_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_CFG   = 2'd1,
    SEQ_ARMED = 2'd2
  } seqState_t;

endpackage

// File: rtl/wdog_seq.sv
module wdog_seq
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWe,
  input  logic [1:0] busAddr,
  input  logic [7:0] busData,
  input  logic       wdReset,
  output wdStrobe_t  strb
);

  seqState_t state, stateNxt;
  logic wrLive, isCfg, isKey1Ok, isKey2Ok;

  always_comb begin
    wrLive   = busWe && !wdReset;
    isCfg    = (busAddr == ADDR_CTRL) || (busAddr == ADDR_RELOAD);
    isKey1Ok = (busAddr == ADDR_KEY1) && (busData == KEY_FIRST);
    isKey2Ok = (busAddr == ADDR_KEY2) && (busData == KEY_SECOND);

    strb     = '0;
    stateNxt = state;

    if (wdReset) begin
      stateNxt = SEQ_IDLE;
    end else if (wrLive) begin
      unique case (state)
        SEQ_IDLE, SEQ_CFG: begin
          if (isCfg) begin
            strb.ctrlWr   = (busAddr == ADDR_CTRL);
            strb.reloadWr = (busAddr == ADDR_RELOAD);
            stateNxt      = SEQ_CFG;
          end else if (isKey1Ok) begin
            stateNxt = SEQ_ARMED;
          end else begin
            strb.badSeq = 1'b1;
            stateNxt    = SEQ_IDLE;
          end
        end
        SEQ_ARMED: begin
          if (isKey2Ok) strb.feedOk = 1'b1;
          else          strb.badSeq = 1'b1;
          stateNxt = SEQ_IDLE;
        end
        default: begin
          strb.badSeq = 1'b1;
          stateNxt    = SEQ_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SEL_W     = 3,
  parameter int PRE_BASE  = 5,
  parameter int PULSE_LEN = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdTick,
  input  wdStrobe_t  strb,
  input  logic [7:0] wrData,
  output logic       wdReset,
  output logic       tripFlag
);

  localparam int SEL_MAX = (1 << SEL_W) - 1;
  localparam int PRE_W   = PRE_BASE + SEL_MAX;
  localparam int PULSE_W = $clog2(PULSE_LEN) + 1;
  localparam logic [PRE_W-1:0] PRE_ONES = '1;

  logic [SEL_W-1:0]   selAct, selStg;
  logic [CNT_W-1:0]   reloadAct, reloadStg;
  logic [PRE_W-1:0]   preCnt, preMask;
  logic [CNT_W-1:0]   toCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic               step, timeoutHit, fire;

  always_comb begin
    preMask    = PRE_ONES >> (SEL_MAX - int'(selAct));
    step       = wdTick && ((preCnt & preMask) == preMask);
    timeoutHit = !wdReset && !strb.feedOk && step && (toCnt <= CNT_W'(1));
    fire       = strb.badSeq || timeoutHit;
  end

  // Configuration: staged by writes, committed by a feed, rolled back on a trip
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selAct    <= '1;
      selStg    <= '1;
      reloadAct <= '1;
      reloadStg <= '1;
    end else if (fire) begin
      selStg    <= selAct;
      reloadStg <= reloadAct;
    end else if (strb.feedOk) begin
      selAct    <= selStg;
      reloadAct <= reloadStg;
    end else begin
      if (strb.ctrlWr)   selStg    <= wrData[SEL_W-1:0];
      if (strb.reloadWr) reloadStg <= CNT_W'(wrData);
    end
  end

  // Prescaler and down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      toCnt  <= '1;
    end else if (fire || wdReset) begin
      preCnt <= '0;
      toCnt  <= reloadAct;
    end else if (strb.feedOk) begin
      preCnt <= '0;
      toCnt  <= reloadStg;
    end else if (wdTick) begin
      preCnt <= preCnt + PRE_W'(1);
      if (step) toCnt <= toCnt - CNT_W'(1);
    end
  end

  // Reset pulse of fixed length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdReset  <= 1'b0;
      pulseCnt <= '0;
    end else if (fire) begin
      wdReset  <= 1'b1;
      pulseCnt <= PULSE_W'(PULSE_LEN - 1);
    end else if (wdReset) begin
      if (pulseCnt == '0) wdReset  <= 1'b0;
      else                pulseCnt <= pulseCnt - PULSE_W'(1);
    end
  end

  // Sticky status flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          tripFlag <= 1'b0;
    else if (fire)                      tripFlag <= 1'b1;
    else if (strb.ctrlWr && wrData[7])  tripFlag <= 1'b0;
  end

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SEL_W     = 3,
  parameter int PRE_BASE  = 5,
  parameter int PULSE_LEN = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdTick,
  input  logic       busWe,
  input  logic [1:0] busAddr,
  input  logic [7:0] busData,
  output logic       wdReset,
  output logic       tripFlag
);

  wdStrobe_t strb;

  wdog_seq uSeq (
    .clk     (clk),
    .rstN    (rstN),
    .busWe   (busWe),
    .busAddr (busAddr),
    .busData (busData),
    .wdReset (wdReset),
    .strb    (strb)
  );

  wdog_datapath #(
    .CNT_W     (CNT_W),
    .SEL_W     (SEL_W),
    .PRE_BASE  (PRE_BASE),
    .PULSE_LEN (PULSE_LEN)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .wdTick   (wdTick),
    .strb     (strb),
    .wrData   (busData),
    .wdReset  (wdReset),
    .tripFlag (tripFlag)
  );

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int PULSE_LEN = 32
) (
  input logic       clk,
  input logic       rstN,
  input logic       wdTick,
  input logic       busWe,
  input logic [1:0] busAddr,
  input logic [7:0] busData,
  input logic       wdReset,
  input logic       tripFlag
);

  int hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        hiCnt <= 0;
    else if (wdReset) hiCnt <= hiCnt + 1;
    else              hiCnt <= 0;
  end

  // R9
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdReset) |-> (hiCnt == PULSE_LEN));

  // R10
  flag_on_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tripFlag) |-> $rose(wdReset));

  // R10
  flag_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |-> tripFlag);

  // R5
  bad_key2_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !wdReset && busAddr == 2'd3 && busData != 8'h5A) |=> wdReset);

  // R12
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wdTick && !busWe && !wdReset) |=> !wdReset);

endmodule

bind wdog_keyed wdog_keyed_chk #(.PULSE_LEN(PULSE_LEN)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .wdTick   (wdTick),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busData  (busData),
  .wdReset  (wdReset),
  .tripFlag (tripFlag)
);

// File: tb/tb_wdog_keyed.sv
`timescale 1ns/1ps
module tb_wdog_keyed;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wdTick = 1'b1;
  logic       busWe = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busData = 8'd0;
  logic       wdReset, tripFlag;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_keyed dut (
    .clk(clk), .rstN(rstN), .wdTick(wdTick), .busWe(busWe),
    .busAddr(busAddr), .busData(busData), .wdReset(wdReset), .tripFlag(tripFlag)
  );

  function automatic int expTimeout(input int sel, input int reload);
    int r;
    r = (reload == 0) ? 1 : reload;
    return r << (5 + sel);
  endfunction

  function automatic bit expBadAfterKey1(input logic [1:0] a, input logic [7:0] d);
    return !(a == 2'd3 && d == 8'h5A);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busData = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic feed();
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitPulseEnd();
    while (wdReset) @(negedge clk);
  endtask

  task automatic expectTimeout(input int t, input string req);
    waitCycles(t - 1);
    check(wdReset == 1'b0, req, int'(wdReset), 0);
    waitCycles(1);
    check(wdReset == 1'b1, req, int'(wdReset), 1);
    waitCycles(31);
    check(wdReset == 1'b1, "R9", int'(wdReset), 1);
    waitCycles(1);
    check(wdReset == 1'b0, "R9", int'(wdReset), 0);
  endtask

  task automatic configure(input int sel, input int reload);
    wr(2'd0, 8'(sel));
    wr(2'd1, 8'(reload));
    feed();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    waitCycles(4);
    rstN = 1'b1;
    waitCycles(2);
    // R1
    check(wdReset == 1'b0, "R1", int'(wdReset), 0);
    check(tripFlag == 1'b0, "R1", int'(tripFlag), 0);

    // R3 R4: sel 0, reload 2 -> 64 cycles
    configure(0, 2);
    expectTimeout(expTimeout(0, 2), "R3");
    check(tripFlag == 1'b1, "R10", int'(tripFlag), 1);

    // R10: clear via control bit 7, effective immediately
    wr(2'd0, 8'h80);
    check(tripFlag == 1'b0, "R10", int'(tripFlag), 0);
    wr(2'd1, 8'd8);
    feed();
    check(wdReset == 1'b0, "R10", int'(wdReset), 0);

    // R2: repeated feeds keep reset low (timeout 256)
    for (int i = 0; i < 5; i++) begin
      waitCycles(100);
      check(wdReset == 1'b0, "R2", int'(wdReset), 0);
      feed();
    end
    expectTimeout(expTimeout(0, 8), "R2");

    // R5: wrong first key value
    wr(2'd2, 8'h33);
    check(wdReset == 1'b1, "R5", int'(wdReset), 1);
    check(tripFlag == 1'b1, "R10", int'(tripFlag), 1);
    waitPulseEnd();
    check(tripFlag == 1'b1, "R10", int'(tripFlag), 1);
    // R5: second key with no first key
    wr(2'd3, 8'h5A);
    check(wdReset == 1'b1, "R5", int'(wdReset), 1);
    waitPulseEnd();

    // R6: control write between keys, and repeated first key
    wr(2'd2, 8'hA5);
    wr(2'd0, 8'h00);
    check(wdReset == 1'b1, "R6", int'(wdReset), 1);
    waitPulseEnd();
    wr(2'd2, 8'hA5);
    wr(2'd2, 8'hA5);
    check(wdReset == 1'b1, "R6", int'(wdReset), 1);
    waitPulseEnd();

    // R11: writes during the pulse are ignored
    wr(2'd3, 8'h00);
    check(wdReset == 1'b1, "R11", int'(wdReset), 1);
    wr(2'd3, 8'h00);
    waitCycles(29);
    check(wdReset == 1'b1, "R11", int'(wdReset), 1);
    waitCycles(1);
    check(wdReset == 1'b0, "R11", int'(wdReset), 0);
    waitCycles(100);
    check(wdReset == 1'b0, "R11", int'(wdReset), 0);

    // R7: config write then second key fires
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h5A);
    check(wdReset == 1'b1, "R7", int'(wdReset), 1);
    waitPulseEnd();
    // R7 R4: back-to-back config writes accepted, sel 1 reload 1 -> 64
    configure(1, 1);
    check(wdReset == 1'b0, "R7", int'(wdReset), 0);
    expectTimeout(expTimeout(1, 1), "R4");
    // R7: config then wrong first key
    wr(2'd1, 8'd4);
    wr(2'd2, 8'h12);
    check(wdReset == 1'b1, "R7", int'(wdReset), 1);
    waitPulseEnd();

    // R8: staged reload 4 discarded, old 64-cycle timeout still in force
    feed();
    expectTimeout(expTimeout(1, 1), "R8");

    // R12: tick stalled holds the count
    configure(0, 1);
    wdTick = 1'b0;
    waitCycles(2000);
    check(wdReset == 1'b0, "R12", int'(wdReset), 0);
    wdTick = 1'b1;
    expectTimeout(expTimeout(0, 1), "R12");

    // R3: reload 0 behaves as 1
    configure(0, 0);
    expectTimeout(expTimeout(0, 0), "R3");

    // Random mix
    for (int i = 0; i < 10; i++) begin
      int sel, rel;
      logic [1:0] a;
      logic [7:0] d;
      sel = int'($urandom % 3);
      rel = 1 + int'($urandom % 6);
      configure(sel, rel);
      expectTimeout(expTimeout(sel, rel), "R3");
      a = 2'($urandom % 4);
      d = (($urandom % 4) == 0) ? 8'h5A : 8'($urandom % 256);
      wr(2'd2, 8'hA5);
      wr(a, d);
      if (expBadAfterKey1(a, d)) begin
        check(wdReset == 1'b1, "R6", int'(wdReset), 1);
        waitPulseEnd();
      end else begin
        check(wdReset == 1'b0, "R2", int'(wdReset), 0);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule